// File: doc/BRIEF.md
# Burst Address Counter with Restart

This block produces the in-bank word address for one port of a synchronous memory. Each clock edge it does one of four things. It can take a new start address from outside, move one word forward for a burst, go back to the word where the current burst began, or keep its value. The address it drives comes straight from a register, so the memory decode that follows sees a clean value for the whole cycle.

The block also keeps a second register with the address that was last loaded from outside. Because of this, the same burst can be replayed any number of times without the external address being driven again. Each port of a dual-port memory has its own instance, clocked by that port's clock. Bank selection bits do not pass through this block.

Top module: `burst_addr_gen`

## Requirements
- R1: When `strobe_n` is 0 and `repeat_n` is 1, `ext_addr` appears on `addr` after the next rising clock edge. It is also stored as the burst start.
- R2: When `cnt_en_n` is 0 and both `strobe_n` and `repeat_n` are 1, `addr` goes up by one at the next rising edge.
- R3: When `repeat_n` is 0, `addr` becomes the stored burst start at the next rising edge.
- R4: Counting up from 8191, the largest 13-bit address, gives 0.
- R5: When all three controls are 1, `addr` keeps its value.
- R6: Repeat has the highest priority, then strobe, then count enable. A strobe given in the same cycle as repeat is ignored and does not change the stored burst start.
- R7: A synchronous active-high `rst` sets both `addr` and the stored burst start to 0.
- R8: Counting up and repeating do not change the stored burst start. Only a strobe that takes effect writes it.
- R9: All three controls are active low. A value of 1 on a control means it is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 13 | External start address |
| strobe_n | input | 1 | Load ext_addr, active low |
| cnt_en_n | input | 1 | Count up by one, active low |
| repeat_n | input | 1 | Return to burst start, active low |
| addr | output | 13 | Current in-bank address, registered |

## Verification
The bench builds the block with its default 13-bit width. This gives an 8192-word space, small enough to sweep completely. Every address is loaded, counted up once and then restored with repeat. The sweep therefore reaches the wrap from 8191 to 0 and shows that the stored start survives counting up at every value. Directed sequences cover control combinations where two or more controls are active at once. They also check the reset state of both registers.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD    = 2'd0,
    CMD_STEP    = 2'd1,
    CMD_LOAD    = 2'd2,
    CMD_RESTART = 2'd3
  } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_ctr_pkg::*;
(
  input  logic       strobe_n,
  input  logic       cnt_en_n,
  input  logic       repeat_n,
  output burst_cmd_e cmd
);
  // Priority: restart, then load, then step (R6, R9)
  always_comb begin
    if (!repeat_n)      cmd = CMD_RESTART;
    else if (!strobe_n) cmd = CMD_LOAD;
    else if (!cnt_en_n) cmd = CMD_STEP;
    else                cmd = CMD_HOLD;
  end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_ctr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_cmd_e        cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (rst)                  start_q <= '0;
    else if (cmd == CMD_LOAD) start_q <= ext_addr;
  end

  AST_START_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_LOAD) |=> $stable(start_q)); // R8
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_ctr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_cmd_e        cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else begin
      unique case (cmd)
        CMD_RESTART: addr_q <= start_q;
        CMD_LOAD:    addr_q <= ext_addr;
        CMD_STEP:    addr_q <= addr_q + ONE;
        default:     addr_q <= addr_q;
      endcase
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_ctr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              cnt_en_n,
  input  logic              repeat_n,
  output logic [ADDR_W-1:0] addr
);
  burst_cmd_e        cmd;
  logic [ADDR_W-1:0] start_q;

  burst_cmd_decode u_dec (
    .strobe_n (strobe_n),
    .cnt_en_n (cnt_en_n),
    .repeat_n (repeat_n),
    .cmd      (cmd)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .ext_addr (ext_addr),
    .start_q  (start_q)
  );

  burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .ext_addr (ext_addr),
    .start_q  (start_q),
    .addr_q   (addr)
  );

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (rst)
    (repeat_n && !strobe_n) |=> (addr == $past(ext_addr))); // R1
  AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (rst)
    (repeat_n && strobe_n && !cnt_en_n) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R2
  AST_REPEAT_TO_START: assert property (@(posedge clk) disable iff (rst)
    (!repeat_n) |=> (addr == $past(start_q))); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (repeat_n && strobe_n && cnt_en_n) |=> $stable(addr)); // R5
  AST_REPEAT_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!repeat_n && !strobe_n) |=> $stable(start_q)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (addr == '0 && start_q == '0)); // R7
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          cnt_en_n = 1'b1;
  logic          repeat_n = 1'b1;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_addr = '0;
  logic [AW-1:0] m_start = '0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr),
    .strobe_n(strobe_n), .cnt_en_n(cnt_en_n), .repeat_n(repeat_n),
    .addr(addr)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: addr=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Called at a negedge: drive, update model per requirements, check at next negedge
  task automatic cyc(input logic s, input logic e, input logic r,
                     input logic [AW-1:0] a, input string req);
    strobe_n = s; cnt_en_n = e; repeat_n = r; ext_addr = a;
    if (!r)      m_addr = m_start;
    else if (!s) begin m_addr = a; m_start = a; end
    else if (!e) m_addr = m_addr + 1'b1;
    @(negedge clk);
    chk(req, addr, m_addr);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset addr", addr, '0);
    rst = 1'b0;
    // R7: saved start is zero after reset
    cyc(1, 1, 1, 13'd0, "R7 idle after reset");
    cyc(1, 1, 0, 13'd0, "R7 repeat after reset");

    // Exhaustive sweep: load, step, repeat at every address
    for (int i = 0; i < (1 << AW); i++) begin
      cyc(0, 1, 1, AW'(i), "R1 load");
      cyc(1, 0, 1, AW'(i ^ 5), (i == (1 << AW) - 1) ? "R4 wrap" : "R2 step");
      cyc(1, 1, 0, AW'(i ^ 9), "R3 repeat");
    end

    // R4 explicit wrap and R8 start unchanged by steps
    cyc(0, 1, 1, 13'd8190, "R1 load 8190");
    cyc(1, 0, 1, 13'd0, "R2 step");
    cyc(1, 0, 1, 13'd0, "R4 wrap to 0");
    cyc(1, 0, 1, 13'd0, "R4 after wrap");
    cyc(1, 1, 0, 13'd0, "R8 start kept through steps");

    // R5 / R9 hold with all controls high
    cyc(0, 1, 1, 13'd1234, "R1 load");
    cyc(1, 0, 1, 13'd77, "R2 step");
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, AW'(k * 311), "R5 R9 idle hold");

    // R6 priority cases
    cyc(0, 0, 1, 13'd4000, "R6 strobe beats enable");
    cyc(0, 1, 0, 13'd6000, "R6 repeat beats strobe");
    cyc(1, 0, 1, 13'd0, "R2 step");
    cyc(1, 1, 0, 13'd0, "R6 start not loaded during repeat");
    cyc(0, 0, 0, 13'd5, "R6 repeat beats all");
    cyc(1, 1, 0, 13'd0, "R8 repeat keeps start");

    // R7 reset mid-burst
    cyc(0, 1, 1, 13'd3333, "R1 load");
    rst = 1'b1;
    @(negedge clk);
    chk("R7 reset clears addr", addr, '0);
    rst = 1'b0;
    m_addr = '0; m_start = '0;
    cyc(1, 1, 0, 13'd0, "R7 reset clears start");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule